// File: doc/BRIEF.md
# Time-Division Secure Memory Request Scheduler

This block sits at the front of a memory controller that is shared by several security domains. It keeps one domain's traffic from changing the timing seen by another. Each incoming request carries a domain number and waits in a FIFO that belongs to that domain alone. A turn timer hands the single issue slot to one domain at a time, in a fixed rotation. Each domain's turn length comes from a static setting.

The tail of every turn is a dead window. No domain issues during it, so commands already sent to the memory devices can finish before the next owner starts. The dead window is 46 cycles in shared-bank mode. It is 8 cycles in split-bank mode. In split-bank mode the banks are divided evenly among the domains, and a request that targets a bank outside its own domain's range is discarded.

Both data interfaces use valid/ready. Upstream, a request moves when `req_valid` and `req_ready` are both high on a rising edge. `req_ready` depends only on whether the addressed domain's queue is full. Downstream, `iss_valid` never waits for `iss_ready`. While a request is offered and not taken, the offered request stays the same for as long as the slot stays open. Configuration pins are plain levels that are sampled on a load pulse.

Top module: `tdm_mem_sched`

## Requirements
- R1: After reset, `iss_valid` and `err_drop` are low and `req_ready` is high. Domain 0 owns the first turn, starting at position 0. Every turn length is 64 cycles and the mode is shared-bank.
- R2: A turn for domain d lasts its configured length L(d), where a length of 0 counts as 1. The next turn then goes to domain (d+1) mod N. Only the owning domain's requests are issued, and `iss_dom` names that domain.
- R3: In the last D positions of each turn, `iss_valid` stays low. D is 46 in shared-bank mode and 8 in split-bank mode. A turn with L(d) ≤ D issues nothing.
- R4: Requests of one domain are issued in arrival order, with `iss_bank` and `iss_addr` unchanged from the request.
- R5: Outside the dead window, `iss_valid` is high exactly when the owner's queue is non-empty. A request leaves on a cycle with `iss_valid` and `iss_ready` both high. While `iss_ready` is low and the slot stays open, the offered request is held stable.
- R6: `req_ready` is low exactly when the queue of the domain on `req_dom` holds DEPTH (default 4) entries. A full queue never blocks another domain's enqueue or issue.
- R7: In split-bank mode (`cfg_split`=1), domain d owns the banks b with floor(b / (2^BANK_W / N)) = d. A request outside that range is accepted and discarded. It is never issued, and `err_drop` is high for one cycle in the cycle after acceptance. In shared-bank mode every bank is allowed.
- R8: A `cfg_load` pulse takes effect only when every queue is empty. It then applies `cfg_turn_len` (domain d at bits [d*TURN_W +: TURN_W]) and `cfg_split`, and the next cycle is position 0 of domain 0's turn. In any other cycle the pulse is ignored and the schedule carries on unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Request to apply the configuration pins |
| cfg_turn_len | input | N_DOM*TURN_W | Turn length per domain |
| cfg_split | input | 1 | 1 = split-bank mode, 0 = shared-bank mode |
| req_valid | input | 1 | Upstream request valid |
| req_ready | output | 1 | Upstream request ready |
| req_dom | input | DOM_W | Domain of the request |
| req_bank | input | BANK_W | Bank of the request |
| req_addr | input | ADDR_W | Row/column address of the request |
| iss_valid | output | 1 | Issued request valid |
| iss_ready | input | 1 | Downstream ready |
| iss_dom | output | DOM_W | Domain of the issued request |
| iss_bank | output | BANK_W | Bank of the issued request |
| iss_addr | output | ADDR_W | Address of the issued request |
| err_drop | output | 1 | One-cycle pulse for a discarded out-of-range request |

## Verification
Enqueue into a domain's queue and issue from that same queue can happen on the same edge. The table-driven phase provokes this by feeding requests to the owner while the slot is open and `iss_ready` is high, and a cycle-accurate model of queue occupancy and order judges the result. A discarded split-bank request can land on the same edge as an issue from another domain, or as a configuration pulse that arrives while a queue is still occupied. In those cases the bench checks the `err_drop` pulse, the unchanged issue stream, and the counted number of open cycles per window, which shows whether the pulse was ignored.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;
  typedef enum logic {
    SCHED_SHARED = 1'b0,
    SCHED_SPLIT  = 1'b1
  } sched_mode_e;

  function automatic int dead_cycles(sched_mode_e mode, int shared_d, int split_d);
    return (mode == SCHED_SPLIT) ? split_d : shared_d;
  endfunction
endpackage

// File: rtl/sched_queue.sv
module sched_queue #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  logic do_push, do_pop;
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign dout  = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CW'(DEPTH));
endmodule

// File: rtl/turn_timer.sv
module turn_timer
  import tdm_sched_pkg::*;
#(
  parameter int N_DOM        = 2,
  parameter int DOM_W        = 1,
  parameter int TURN_W       = 8,
  parameter int DEAD_SHARED  = 46,
  parameter int DEAD_SPLIT   = 8,
  parameter int DEFAULT_TURN = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load,
  input  logic [N_DOM*TURN_W-1:0] load_len,
  input  logic                    load_split,
  output logic [DOM_W-1:0]        owner,
  output logic [TURN_W-1:0]       pos,
  output logic [TURN_W-1:0]       cur_len,
  output logic                    slot_open,
  output logic                    split_mode
);
  logic [TURN_W-1:0] len_q [N_DOM];
  sched_mode_e       mode_q;
  logic [DOM_W-1:0]  owner_q;
  logic [TURN_W-1:0] pos_q;
  logic [31:0]       dead_len;
  logic              turn_end;

  assign cur_len  = (len_q[owner_q] == '0) ? TURN_W'(1) : len_q[owner_q];
  assign dead_len = 32'(dead_cycles(mode_q, DEAD_SHARED, DEAD_SPLIT));
  assign slot_open = (32'(pos_q) + dead_len) < 32'(cur_len);
  assign turn_end  = (pos_q == cur_len - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int d = 0; d < N_DOM; d++) len_q[d] <= TURN_W'(DEFAULT_TURN);
      mode_q  <= SCHED_SHARED;
      owner_q <= '0;
      pos_q   <= '0;
    end else if (load) begin
      for (int d = 0; d < N_DOM; d++) len_q[d] <= load_len[d*TURN_W +: TURN_W];
      mode_q  <= load_split ? SCHED_SPLIT : SCHED_SHARED;
      owner_q <= '0;
      pos_q   <= '0;
    end else if (turn_end) begin
      pos_q   <= '0;
      owner_q <= (owner_q == DOM_W'(N_DOM - 1)) ? '0 : owner_q + 1'b1;
    end else begin
      pos_q   <= pos_q + 1'b1;
    end
  end

  assign owner      = owner_q;
  assign pos        = pos_q;
  assign split_mode = (mode_q == SCHED_SPLIT);
endmodule

// File: rtl/bank_guard.sv
module bank_guard #(
  parameter int N_DOM  = 2,
  parameter int DOM_W  = 1,
  parameter int BANK_W = 2
) (
  input  logic              split,
  input  logic [DOM_W-1:0]  dom,
  input  logic [BANK_W-1:0] bank,
  output logic              ok
);
  localparam int NBANK = 1 << BANK_W;
  localparam int PER   = (NBANK / N_DOM > 0) ? NBANK / N_DOM : 1;

  logic [31:0] bank_owner;
  assign bank_owner = 32'(bank) / 32'(PER);
  assign ok = !split || (bank_owner == 32'(dom));
endmodule

// File: rtl/tdm_mem_sched.sv
module tdm_mem_sched #(
  parameter int N_DOM        = 2,
  parameter int DOM_W        = (N_DOM > 1) ? $clog2(N_DOM) : 1,
  parameter int TURN_W       = 8,
  parameter int BANK_W       = 2,
  parameter int ADDR_W       = 12,
  parameter int DEPTH        = 4,
  parameter int DEAD_SHARED  = 46,
  parameter int DEAD_SPLIT   = 8,
  parameter int DEFAULT_TURN = 64
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [N_DOM*TURN_W-1:0] cfg_turn_len,
  input  logic                    cfg_split,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [DOM_W-1:0]        req_dom,
  input  logic [BANK_W-1:0]       req_bank,
  input  logic [ADDR_W-1:0]       req_addr,
  output logic                    iss_valid,
  input  logic                    iss_ready,
  output logic [DOM_W-1:0]        iss_dom,
  output logic [BANK_W-1:0]       iss_bank,
  output logic [ADDR_W-1:0]       iss_addr,
  output logic                    err_drop
);
  localparam int EW = BANK_W + ADDR_W;

  logic [DOM_W-1:0]  owner;
  logic [TURN_W-1:0] pos;
  logic [TURN_W-1:0] cur_len;
  logic              slot_open;
  logic              split_mode;
  logic              bank_ok;
  logic              accept;
  logic              load_go;

  logic [EW-1:0] head    [N_DOM];
  logic [N_DOM-1:0] empty_v, full_v, push_v, pop_v;

  assign load_go = cfg_load && (&empty_v);

  turn_timer #(
    .N_DOM(N_DOM), .DOM_W(DOM_W), .TURN_W(TURN_W),
    .DEAD_SHARED(DEAD_SHARED), .DEAD_SPLIT(DEAD_SPLIT),
    .DEFAULT_TURN(DEFAULT_TURN)
  ) timer_i (
    .clk(clk), .rst_n(rst_n),
    .load(load_go), .load_len(cfg_turn_len), .load_split(cfg_split),
    .owner(owner), .pos(pos), .cur_len(cur_len),
    .slot_open(slot_open), .split_mode(split_mode)
  );

  bank_guard #(.N_DOM(N_DOM), .DOM_W(DOM_W), .BANK_W(BANK_W)) guard_i (
    .split(split_mode), .dom(req_dom), .bank(req_bank), .ok(bank_ok)
  );

  assign req_ready = !full_v[req_dom];
  assign accept    = req_valid && req_ready;

  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    assign push_v[d] = accept && bank_ok && (req_dom == DOM_W'(d));
    assign pop_v[d]  = iss_valid && iss_ready && (owner == DOM_W'(d));
    sched_queue #(.W(EW), .DEPTH(DEPTH)) q_i (
      .clk(clk), .rst_n(rst_n),
      .push(push_v[d]), .din({req_bank, req_addr}),
      .pop(pop_v[d]), .dout(head[d]),
      .empty(empty_v[d]), .full(full_v[d])
    );
  end

  assign iss_valid            = slot_open && !empty_v[owner];
  assign iss_dom              = owner;
  assign {iss_bank, iss_addr} = head[owner];

  always_ff @(posedge clk) begin
    if (!rst_n) err_drop <= 1'b0;
    else        err_drop <= accept && !bank_ok;
  end
endmodule

// File: rtl/tdm_sched_chk.sv
module tdm_sched_chk #(
  parameter int DOM_W  = 1,
  parameter int TURN_W = 8,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              iss_valid,
  input logic              iss_ready,
  input logic [BANK_W-1:0] iss_bank,
  input logic [ADDR_W-1:0] iss_addr,
  input logic              err_drop,
  input logic              slot_open,
  input logic [DOM_W-1:0]  owner,
  input logic [TURN_W-1:0] pos,
  input logic [TURN_W-1:0] cur_len
);
  // R3: the queue side never offers while the timer reports the dead window
  p_dead_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_open |-> !iss_valid);

  // R5: an offer that is not taken is held while the slot stays open
  p_hold_offer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |=>
      (!slot_open || (iss_valid && $stable(iss_bank) && $stable(iss_addr))));

  // R7: an error pulse always follows an accepted request
  p_err_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_drop |-> $past(req_valid && req_ready));

  // R2: ownership changes only at the start of a turn
  p_owner_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (owner != $past(owner)) |-> (pos == '0));

  // R2: position stays inside the current turn
  p_turn_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pos < cur_len);
endmodule

bind tdm_mem_sched tdm_sched_chk #(
  .DOM_W(DOM_W), .TURN_W(TURN_W), .BANK_W(BANK_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(req_valid), .req_ready(req_ready),
  .iss_valid(iss_valid), .iss_ready(iss_ready),
  .iss_bank(iss_bank), .iss_addr(iss_addr),
  .err_drop(err_drop), .slot_open(slot_open),
  .owner(owner), .pos(pos), .cur_len(cur_len)
);

// File: tb/tdm_mem_sched_tb_top.sv
module tdm_mem_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // vector: {dom[1], bank[2], addr[12], iss_ready[1], gap[4]}
  localparam logic [19:0] VEC [NV] = '{
    {1'b0, 2'd0, 12'h101, 1'b1, 4'd0},
    {1'b0, 2'd1, 12'h102, 1'b1, 4'd0},
    {1'b1, 2'd2, 12'h201, 1'b1, 4'd2},
    {1'b0, 2'd3, 12'h103, 1'b0, 4'd1},
    {1'b1, 2'd0, 12'h202, 1'b0, 4'd0},
    {1'b1, 2'd3, 12'h203, 1'b1, 4'd5},
    {1'b0, 2'd2, 12'h104, 1'b1, 4'd0},
    {1'b0, 2'd0, 12'h105, 1'b1, 4'd0},
    {1'b0, 2'd1, 12'h106, 1'b1, 4'd0},
    {1'b1, 2'd1, 12'h204, 1'b0, 4'd3},
    {1'b1, 2'd2, 12'h205, 1'b1, 4'd0},
    {1'b0, 2'd3, 12'h107, 1'b1, 4'd7}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic c_load = 1'b0;
  logic [15:0] c_len = {8'd64, 8'd64};
  logic c_split = 1'b0;
  logic r_valid = 1'b0;
  logic r_dom = 1'b0;
  logic [1:0] r_bank = '0;
  logic [11:0] r_addr = '0;
  logic i_ready = 1'b0;
  logic req_ready, iss_valid, err_drop;
  logic iss_dom;
  logic [1:0] iss_bank;
  logic [11:0] iss_addr;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tdm_mem_sched dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_load(c_load), .cfg_turn_len(c_len), .cfg_split(c_split),
    .req_valid(r_valid), .req_ready(req_ready), .req_dom(r_dom),
    .req_bank(r_bank), .req_addr(r_addr),
    .iss_valid(iss_valid), .iss_ready(i_ready), .iss_dom(iss_dom),
    .iss_bank(iss_bank), .iss_addr(iss_addr), .err_drop(err_drop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // reference model of the schedule and queues
  int m_own, m_pos, m_cnt [2];
  int m_len [2];
  bit m_split, m_err;
  logic [13:0] m_q [2][4];

  always @(negedge clk) begin
    if (!rst_n) begin
      m_own = 0; m_pos = 0; m_cnt[0] = 0; m_cnt[1] = 0;
      m_len[0] = 64; m_len[1] = 64; m_split = 0; m_err = 0;
    end else if (!done) begin
      int el, dd, rd;
      bit open, ev, er, acc, bad, idle;
      el = (m_len[m_own] == 0) ? 1 : m_len[m_own];
      dd = m_split ? 8 : 46;
      open = (m_pos + dd) < el;
      ev = open && (m_cnt[m_own] > 0);
      if (open) chk(iss_valid == ev, "R5 offer", int'(iss_valid), int'(ev));
      else      chk(iss_valid == ev, "R3 dead window", int'(iss_valid), int'(ev));
      if (ev && iss_valid) begin
        chk(int'(iss_dom) == m_own, "R2 owner", int'(iss_dom), m_own);
        chk({iss_bank, iss_addr} == m_q[m_own][0], "R4 order",
            int'({iss_bank, iss_addr}), int'(m_q[m_own][0]));
      end
      rd = int'(r_dom);
      er = m_cnt[rd] < 4;
      chk(req_ready == er, "R6 ready", int'(req_ready), int'(er));
      chk(err_drop == m_err, "R7 err pulse", int'(err_drop), int'(m_err));
      acc  = r_valid && er;
      bad  = m_split && ((int'(r_bank) / 2) != rd);
      idle = (m_cnt[0] == 0) && (m_cnt[1] == 0);
      m_err = acc && bad;
      if (ev && i_ready) begin
        for (int k = 0; k < 3; k++) m_q[m_own][k] = m_q[m_own][k+1];
        m_cnt[m_own]--;
      end
      if (acc && !bad) begin
        m_q[rd][m_cnt[rd]] = {r_bank, r_addr};
        m_cnt[rd]++;
      end
      if (c_load && idle) begin
        m_len[0] = int'(c_len[7:0]); m_len[1] = int'(c_len[15:8]);
        m_split = c_split; m_own = 0; m_pos = 0;
      end else if (m_pos == el - 1) begin
        m_pos = 0; m_own = (m_own + 1) % 2;
      end else begin
        m_pos++;
      end
    end
  end

  task automatic push(input logic d, input logic [1:0] b, input logic [11:0] a);
    r_valid = 1'b1; r_dom = d; r_bank = b; r_addr = a;
    while (!req_ready) step();
    step();
    r_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400; k++) begin
      if (m_cnt[0] == 0 && m_cnt[1] == 0) break;
      step();
    end
  endtask

  initial begin : watchdog
    for (int k = 0; k < 150000; k++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    chk(iss_valid == 1'b0, "R1 reset valid", int'(iss_valid), 0);
    chk(req_ready == 1'b1, "R1 reset ready", int'(req_ready), 1);
    chk(err_drop == 1'b0, "R1 reset err", int'(err_drop), 0);
    rst_n = 1'b1;
    // first offer from domain 0 at position 0
    r_valid = 1'b1; r_dom = 1'b0; r_bank = 2'd1; r_addr = 12'h0AA; i_ready = 1'b0;
    step();
    r_valid = 1'b0;
    @(negedge clk);
    chk(iss_valid == 1'b1 && iss_dom == 1'b0, "R1 first turn domain 0",
        int'(iss_valid), 1);
    #(CLK_PERIOD/2 + 1);
    i_ready = 1'b1;
    drain();

    // table-driven phase, shared mode
    for (int v = 0; v < NV; v++) begin
      i_ready = VEC[v][4];
      push(VEC[v][19], VEC[v][18:17], VEC[v][16:5]);
      for (int g = 0; g < int'(VEC[v][3:0]); g++) step();
    end
    i_ready = 1'b1;
    drain();

    // R6: full domain 0 does not block domain 1
    i_ready = 1'b0;
    for (int k = 0; k < 4; k++) push(1'b0, 2'(k), 12'h300 + 12'(k));
    r_dom = 1'b0;
    #1;
    chk(req_ready == 1'b0, "R6 full domain blocks itself", int'(req_ready), 0);
    r_dom = 1'b1;
    #1;
    chk(req_ready == 1'b1, "R6 other domain still ready", int'(req_ready), 1);
    push(1'b1, 2'd3, 12'h3F0);

    // R8: load while busy is ignored; 128-cycle window keeps 18 open cycles for domain 0
    c_len = {8'd12, 8'd12}; c_split = 1'b1; c_load = 1'b1;
    step();
    c_load = 1'b0;
    n = 0;
    for (int k = 0; k < 128; k++) begin
      @(negedge clk);
      if (iss_valid && iss_dom == 1'b0) n++;
    end
    chk(n == 18, "R8 busy load ignored (R3 shared dead)", n, 18);
    #(CLK_PERIOD/2 + 1);
    i_ready = 1'b1;
    drain();

    // R8: accepted load, split mode, lengths 12 and 20
    c_len = {8'd20, 8'd12}; c_split = 1'b1; c_load = 1'b1;
    step();
    c_load = 1'b0;
    i_ready = 1'b0;
    push(1'b1, 2'd2, 12'h4A0);
    n = 0;
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      if (iss_valid && iss_dom == 1'b1) n++;
    end
    chk(n == 12, "R8 load applied (R3 split dead)", n, 12);
    #(CLK_PERIOD/2 + 1);
    i_ready = 1'b1;
    drain();

    // R7: out-of-range bank dropped with a pulse, in-range request kept
    i_ready = 1'b0;
    r_valid = 1'b1; r_dom = 1'b0; r_bank = 2'd2; r_addr = 12'h5BB;
    step();
    r_valid = 1'b0;
    chk(err_drop == 1'b1, "R7 pulse after bad bank", int'(err_drop), 1);
    step();
    chk(err_drop == 1'b0, "R7 pulse lasts one cycle", int'(err_drop), 0);
    push(1'b0, 2'd1, 12'h5CC);
    i_ready = 1'b1;
    n = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (iss_valid && iss_dom == 1'b0) n++;
    end
    chk(n == 1, "R7 dropped request never issued", n, 1);
    #(CLK_PERIOD/2 + 1);
    drain();
    step();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule